// File: doc/BRIEF.md
# Recursive Systematic Convolutional Encoder with Built-in Trellis Flush

This block is a rate-1/3 recursive systematic convolutional encoder with three delay stages, so it has eight states. On each cycle in which it advances, it takes one data bit and produces one systematic bit and two parity bits. Both parity bits come from the same recursive feedback loop. The feedback polynomial is 1 + D^2 + D^3. The first parity bit uses the numerator 1 + D + D^3 and the second uses 1 + D + D^2 + D^3.

The block is meant to sit inside a larger coding chain, which decides where each block starts and ends. To close a block, the chain raises the terminate control for three advancing cycles. During those cycles the encoder replaces its data input with its own feedback value, which walks the state back to zero. The parity outputs keep running while this happens, and the systematic output carries the forced tail input. The advance enable freezes the block completely while it is low, and a synchronous clear returns the block to the all-zero starting point.

The output bits are registered. The outputs for an advancing cycle appear one clock after the edge that took the input.

Top module: `rsc_encoder`

## Requirements
- R1: While rst_n is low, the state and all outputs (sys_out, par_out) are zero, and they change to zero without waiting for a clock edge.
- R2: On an advancing edge (en=1, clr=0, term=0), sys_out takes the value of din from that edge and keeps it until the next advancing edge.
- R3: The state is a three-stage shift register. On each advancing edge, the new first stage gets din XOR the feedback, where the feedback is the XOR of the second and third stages (polynomial 1 + D^2 + D^3). Every other stage takes the value of the stage before it.
- R4: par_out[0] is the first parity bit. It is the new first-stage bit XOR stage one XOR stage three (numerator 1 + D + D^3). From the zero state, a single 1 followed by zeros gives 1,1,1,1 on par_out[0].
- R5: par_out[1] is the second parity bit. It is the new first-stage bit XOR all three stages (numerator 1 + D + D^2 + D^3). From the zero state, a single 1 followed by zeros gives 1,1,0,1 on par_out[1].
- R6: On an advancing edge with term=1, din is ignored and the input is replaced by the feedback value. sys_out carries that feedback value, and both parity outputs keep being computed from the state.
- R7: After three advancing edges with term=1 in a row, the state is all zero, whatever it was before. A following zero input then gives sys_out=0 and par_out=0.
- R8: While en=0 and clr=0, an edge changes neither the state nor any output, whatever din and term are.
- R9: clr=1 at an edge clears the state and all outputs to zero, whether en is high or low. The next block then starts from the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of state and outputs; overrides en |
| en | input | 1 | Advance enable; low freezes the block |
| term | input | 1 | Terminate: replace the input with the feedback value |
| din | input | 1 | Data bit to encode |
| sys_out | output | 1 | Systematic bit (registered) |
| par_out | output | 2 | Parity bits: [0] first numerator, [1] second numerator |

## Verification
A unit impulse from the zero state shows the recursive response, so it is the first pattern applied. Because the two numerators share a feedback loop, the impulse separates the two parity taps from each other and from the feedback taps. Enabled cycles alternating with frozen ones show that a frozen edge leaves the state alone, and a frozen edge that has term raised confirms that term has no effect without en. Flushes from many pseudo-random states, including ones with a frozen edge in the middle of the tail, confirm that three terminate cycles always reach zero and that din is ignored while terminating. A clear applied from a nonzero state, followed by an impulse, distinguishes a real state clear from a mere output clear.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

   // One operation is chosen per clock edge. A clear wins over everything,
   // a low enable freezes the block, and term picks the flush input.
   typedef enum logic [1:0] {
      RSC_HOLD  = 2'd0,
      RSC_CLEAR = 2'd1,
      RSC_FEED  = 2'd2,
      RSC_FLUSH = 2'd3
   } rsc_op_e;

   function automatic logic rsc_advances(input rsc_op_e op);
      return (op == RSC_FEED) || (op == RSC_FLUSH);
   endfunction

endpackage

// File: rtl/rsc_op_decode.sv
module rsc_op_decode
   import rsc_pkg::*;
(
   input  logic    clr,
   input  logic    en,
   input  logic    term,
   output rsc_op_e op
);

   always_comb begin
      if (clr)       op = RSC_CLEAR;
      else if (!en)  op = RSC_HOLD;
      else if (term) op = RSC_FLUSH;
      else           op = RSC_FEED;
   end

endmodule

// File: rtl/rsc_state_chain.sv
module rsc_state_chain
   import rsc_pkg::*;
#(
   parameter int           MEM     = 3,
   parameter logic [MEM:0] FB_POLY = 4'b1101
) (
   input  logic           clk,
   input  logic           rst_n,
   input  rsc_op_e        op,
   input  logic           din,
   output logic [MEM-1:0] state_q,
   output logic           u_bit,
   output logic           w_bit
);

   // state_q[k-1] holds the value delayed by k cycles
   logic           fb_bit;
   logic [MEM-1:0] state_nx;

   assign fb_bit = ^(state_q & FB_POLY[MEM:1]);
   assign u_bit  = (op == RSC_FLUSH) ? fb_bit : din;
   assign w_bit  = u_bit ^ fb_bit;

   generate
      if (MEM == 1) begin : g_single
         assign state_nx = w_bit;
      end else begin : g_chain
         assign state_nx = {state_q[MEM-2:0], w_bit};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 state_q <= '0;
      else if (op == RSC_CLEAR)   state_q <= '0;
      else if (rsc_advances(op))  state_q <= state_nx;
   end

endmodule

// File: rtl/rsc_parity_tap.sv
module rsc_parity_tap #(
   parameter int           MEM  = 3,
   parameter logic [MEM:0] POLY = 4'b1011
) (
   input  logic           w_bit,
   input  logic [MEM-1:0] state_q,
   output logic           par
);

   assign par = (POLY[0] & w_bit) ^ (^(state_q & POLY[MEM:1]));

endmodule

// File: rtl/rsc_out_reg.sv
module rsc_out_reg
   import rsc_pkg::*;
#(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  rsc_op_e      op,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 q <= '0;
      else if (op == RSC_CLEAR)   q <= '0;
      else if (rsc_advances(op))  q <= d;
   end

endmodule

// File: rtl/rsc_encoder.sv
module rsc_encoder
   import rsc_pkg::*;
#(
   parameter int                         MEM      = 3,
   parameter int                         NUM_PAR  = 2,
   parameter logic [MEM:0]               FB_POLY  = 4'b1101,
   parameter logic [NUM_PAR-1:0][MEM:0]  PAR_POLY = {4'b1111, 4'b1011}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               en,
   input  logic               term,
   input  logic               din,
   output logic               sys_out,
   output logic [NUM_PAR-1:0] par_out
);

   localparam int OUT_W = NUM_PAR + 1;

   generate
      if (MEM < 1) begin : g_bad_mem
         $error("rsc_encoder: MEM must be at least 1");
      end
      if (NUM_PAR < 1) begin : g_bad_par
         $error("rsc_encoder: NUM_PAR must be at least 1");
      end
      if (FB_POLY[0] != 1'b1) begin : g_bad_fb
         $error("rsc_encoder: feedback polynomial needs a constant term");
      end
   endgenerate

   rsc_op_e        op;
   logic [MEM-1:0] state_q;
   logic           u_bit;
   logic           w_bit;
   logic [NUM_PAR-1:0] par_d;
   logic [OUT_W-1:0]   out_q;

   rsc_op_decode dec_i (
      .clr  (clr),
      .en   (en),
      .term (term),
      .op   (op)
   );

   rsc_state_chain #(
      .MEM     (MEM),
      .FB_POLY (FB_POLY)
   ) chain_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .din     (din),
      .state_q (state_q),
      .u_bit   (u_bit),
      .w_bit   (w_bit)
   );

   generate
      for (genvar g = 0; g < NUM_PAR; g++) begin : g_par
         rsc_parity_tap #(
            .MEM  (MEM),
            .POLY (PAR_POLY[g])
         ) tap_i (
            .w_bit   (w_bit),
            .state_q (state_q),
            .par     (par_d[g])
         );
      end
   endgenerate

   rsc_out_reg #(
      .W (OUT_W)
   ) oreg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .d     ({par_d, u_bit}),
      .q     (out_q)
   );

   assign sys_out = out_q[0];
   assign par_out = out_q[OUT_W-1:1];

endmodule

// File: rtl/rsc_encoder_chk.sv
module rsc_encoder_chk #(
   parameter int MEM     = 3,
   parameter int NUM_PAR = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               clr,
   input logic               en,
   input logic               term,
   input logic               din,
   input logic               sys_out,
   input logic [NUM_PAR-1:0] par_out,
   input logic [MEM-1:0]     state_q
);

   localparam int CW = $clog2(MEM + 1) + 1;

   // Counts terminate edges in a row; frozen edges neither count nor break the run
   logic [CW-1:0] flush_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flush_cnt <= '0;
      else if (clr)               flush_cnt <= '0;
      else if (en && !term)       flush_cnt <= '0;
      else if (en && term && (flush_cnt < CW'(MEM)))
                                  flush_cnt <= flush_cnt + 1'b1;
   end

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sys_out == 1'b0 && par_out == '0 && state_q == '0));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !en) |=> ($stable(sys_out) && $stable(par_out) && $stable(state_q)));

   assert_sys_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && en && !term) |=> (sys_out == $past(din)));

   assert_tail_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && en && term && state_q == '0) |=> (sys_out == 1'b0 && par_out == '0));

   assert_flushed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_cnt >= CW'(MEM)) |-> (state_q == '0));

   generate
      if (MEM > 1) begin : g_shift
         assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && en) |=> (state_q[MEM-1:1] == $past(state_q[MEM-2:0])));
      end
   endgenerate

endmodule

bind rsc_encoder rsc_encoder_chk #(
   .MEM     (MEM),
   .NUM_PAR (NUM_PAR)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .clr     (clr),
   .en      (en),
   .term    (term),
   .din     (din),
   .sys_out (sys_out),
   .par_out (par_out),
   .state_q (state_q)
);

// File: tb/rsc_encoder_tb_top.sv
`timescale 1ns/1ps
module rsc_encoder_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0;
   logic       en = 1'b0;
   logic       term = 1'b0;
   logic       din = 1'b0;
   logic       sys_out;
   logic [1:0] par_out;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   rsc_encoder dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .en      (en),
      .term    (term),
      .din     (din),
      .sys_out (sys_out),
      .par_out (par_out)
   );

   // {en, term, din, exp_sys, exp_par0, exp_par1}
   localparam logic [5:0] VEC [0:12] = '{
      6'b101_111, 6'b100_011, 6'b100_010, 6'b100_011,
      6'b001_011, 6'b101_110, 6'b111_010, 6'b110_111,
      6'b111_000, 6'b100_000, 6'b101_111, 6'b010_111,
      6'b101_100
   };

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [2:0] outs();
      return {sys_out, par_out[0], par_out[1]};
   endfunction

   // Bench model: history of the value entering the first delay stage
   logic m1, m2, m3;
   logic [2:0] m_out;

   task automatic model_step(input logic e, input logic t, input logic d);
      logic f, u, w;
      if (!e) return;
      f = m2 ^ m3;
      u = t ? f : d;
      w = u ^ f;
      m_out = {u, w ^ m1 ^ m3, w ^ m1 ^ m2 ^ m3};
      m3 = m2; m2 = m1; m1 = w;
   endtask

   task automatic step(input logic e, input logic t, input logic d);
      en = e; term = t; din = d;
      model_step(e, t, d);
      @(negedge clk);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      @(negedge clk);
      @(negedge clk);
      check("R1 reset", outs(), 3'b000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", outs(), 3'b000);

      // Table walk: impulse response, frozen edges, flush, restart
      for (int i = 0; i <= 12; i++) begin
         en = VEC[i][5]; term = VEC[i][4]; din = VEC[i][3];
         @(negedge clk);
         check($sformatf("vector %0d R2/R3/R4/R5/R6/R7/R8", i), outs(), VEC[i][2:0]);
      end

      // Clear from nonzero state while frozen, then impulse
      clr = 1'b1; en = 1'b0; term = 1'b0; din = 1'b1;
      @(negedge clk);
      check("R9 clear outputs", outs(), 3'b000);
      clr = 1'b0; en = 1'b1; din = 1'b1;
      @(negedge clk);
      check("R9 clear restarts from zero state", outs(), 3'b111);
      en = 1'b1; din = 1'b0;
      @(negedge clk);
      check("R9 impulse second bit", outs(), 3'b011);

      // Clear while enabled
      clr = 1'b1; en = 1'b1; din = 1'b1;
      @(negedge clk);
      check("R9 clear overrides enable", outs(), 3'b000);
      clr = 1'b0;

      // Pseudo-random blocks, each flushed and verified against the model
      m1 = 1'b0; m2 = 1'b0; m3 = 1'b0; m_out = 3'b000;
      lfsr = 16'hACE1;
      for (int blk = 0; blk < 40; blk++) begin
         for (int c = 0; c < 25; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3], lfsr[5] & ~(lfsr[0] | lfsr[3]), lfsr[7]);
            check("R2/R3/R4/R5/R8 random", outs(), m_out);
         end
         for (int k = 0; k < 3; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (k == 1 && lfsr[2]) begin
               step(1'b0, 1'b1, lfsr[4]);
               check("R8 frozen inside tail", outs(), m_out);
            end
            step(1'b1, 1'b1, lfsr[9]);
            check("R6 tail bit", outs(), m_out);
         end
         step(1'b1, 1'b0, 1'b0);
         check("R7 state flushed to zero", outs(), 3'b000);
      end

      // Asynchronous reset in the middle of activity
      step(1'b1, 1'b0, 1'b1);
      #1 rst_n = 1'b0;
      #0.5;
      check("R1 async reset mid-run", outs(), 3'b000);
      @(negedge clk);
      rst_n = 1'b1;
      en = 1'b1; term = 1'b0; din = 1'b1;
      @(negedge clk);
      check("R1 restart after reset", outs(), 3'b111);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule